// File: doc/BRIEF.md
# Expandable Strobe-Driven FIFO with Read Rewind

This block is a first-in first-out word store. By default it holds 512 words of 9 bits. Reads and writes are framed by active-low strobes that are sampled on a system clock and turned into edges internally. A write cycle opens on the falling edge of the write strobe. The data word is taken, and the write position moves on, when the strobe rises again. A read cycle opens on the falling edge of the read strobe, which places the oldest word on the output. The read position moves on when the read strobe rises. Full and empty flags come from an occupancy count, and each of them blocks the cycle that would overrun the store. An output-enable marks when the data bus would be driven, in place of a tri-state bus.

The operating mode is taken from pin straps during reset. If both expansion inputs are held low, the device runs alone. In that mode, a low pulse on the dual-purpose first-load/rewind pin moves the read position back to the first location, so the stored data can be read again. If either expansion input is high, the device is one link of a ring of identical devices that share strobes and data. A low level on the first-load pin marks the link that starts out holding both the write token and the read token. A link only accepts strobes while it holds the matching token. When it finishes an access to its last location, it passes that token on with a one-cycle low pulse on the matching expansion output.

Top module: `exp_fifo`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears both positions to location 0 and sets the occupancy to zero. After reset, empty is 1, full is 0, dout_oe is 0, dout is 0 and both expansion outputs are 1.
- R2: A write cycle opens when wr_n is sampled falling while full is 0 and the device holds the write token. The word on din in the clock cycle where wr_n is first sampled high again is the one stored. Any value driven on din between the fall and the rise is not stored.
- R3: A read cycle opens when rd_n is sampled falling while empty is 0 and the device holds the read token. The oldest word appears on dout one clock after the fall is sampled. The read position advances when rd_n is sampled rising.
- R4: full is 1 exactly when DEPTH words are held. A write cycle that starts while full is 1 is discarded. full returns to 0 once a read cycle completes.
- R5: empty is 1 exactly when no word is held. A read cycle that starts while empty is 1 neither moves the read position nor changes the flags. empty returns to 0 once a write cycle completes.
- R6: Words come out in the order they were written, including when the positions wrap from DEPTH-1 back to 0.
- R7: dout_oe is 1 one clock after rd_n is sampled low, provided the read token is held. It is 0 one clock after rd_n is sampled high. dout is all zeros whenever dout_oe is 0.
- R8: Standalone mode is selected when xi_wr_n and xi_rd_n are both low during reset. In that mode, the rising end of a low pulse on fl_rt_n rewinds the read position to location 0 and leaves the write position unchanged. The occupancy then equals the write position, or equals DEPTH when the write position has wrapped back to 0 after at least one full lap.
- R9: A rewind pulse whose rising end is sampled while rd_n or wr_n is low, or while a read or write cycle is open, is ignored.
- R10: In chained mode, the link with fl_rt_n low during reset starts with both tokens and every other link starts with none. A link without the write token ignores write strobes. A link without the read token ignores read strobes and keeps dout_oe at 0.
- R11: In chained mode, completing a write to location DEPTH-1 drops the write token and drives xo_wr_n low for exactly one clock. Completing a read from location DEPTH-1 does the same for the read token and xo_rd_n. A link that samples its xi_wr_n or xi_rd_n low takes that token. In standalone mode both expansion outputs stay at 1.
- R12: In chained mode, pulses on fl_rt_n never move the read position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; mode straps are taken while it is low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | WIDTH | Write data, taken when wr_n rises |
| fl_rt_n | input | 1 | First-load strap during reset in chained mode; rewind pulse in standalone mode |
| xi_wr_n | input | 1 | Write-token input from the previous link; tie low for standalone mode |
| xi_rd_n | input | 1 | Read-token input from the previous link; tie low for standalone mode |
| dout | output | WIDTH | Read data, all zeros while dout_oe is 0 |
| dout_oe | output | 1 | Marks the cycles in which the data bus would be driven |
| full | output | 1 | High when DEPTH words are held |
| empty | output | 1 | High when no word is held |
| xo_wr_n | output | 1 | One-clock low pulse that hands the write token to the next link |
| xo_rd_n | output | 1 | One-clock low pulse that hands the read token to the next link |

## Verification
The bench runs a standalone 8-deep device through several patterns:
- A fill to the brim followed by a drain, which separates the exact point where full rises from the point where empty rises. The same pattern shows that an extra write is dropped.
- A staircase of bursts whose lengths run from 1 to the full depth, which pushes both positions across the wrap many times at every occupancy.
- Reads on an empty store, whose effect can only be seen in the word returned after the next write.

On every write, din holds a decoy value during the cycle and the real word only at the rising strobe, so a design that samples data on the wrong edge returns wrong words.

Rewind is tried in three situations: after a partial read, after exactly one full lap, and with a strobe held low. These separate the occupancy rule from the ignore rule.

A ring of two 4-deep links shows that the tokens are handed on, that only the token holder drives data, and that a pulse on the first-load pin has no effect.

// File: rtl/exp_fifo_pkg.sv
package exp_fifo_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_CHAIN  = 1'b1
    } fifo_mode_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } strobe_ev_t;

    // Occupancy after a read rewind: every word from location 0 up to the
    // write position is readable again; a write position back at 0 after a
    // completed lap means the whole store is readable.
    function automatic int unsigned rewind_level(input int unsigned wpos,
                                                 input logic        lapped,
                                                 input int unsigned depth);
        if (wpos == 0 && lapped)
            return depth;
        return wpos;
    endfunction

endpackage

// File: rtl/exp_fifo_edge.sv
module exp_fifo_edge
    import exp_fifo_pkg::*;
#(
    parameter int N = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           lvl_n,
    output strobe_ev_t [N-1:0]     ev
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_n;

        always_ff @(posedge clk) begin
            if (!rst_n)
                prev_n <= 1'b1;
            else
                prev_n <= lvl_n[i];
        end

        assign ev[i].fall = prev_n & ~lvl_n[i];
        assign ev[i].rise = ~prev_n & lvl_n[i];
    end

endmodule

// File: rtl/exp_fifo_ram.sv
module exp_fifo_ram #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        if (re)
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/exp_fifo_token.sv
module exp_fifo_token (
    input  logic clk,
    input  logic rst_n,
    input  logic init_have,
    input  logic chain,
    input  logic xi_n,
    input  logic pass,
    output logic have,
    output logic xo_n
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have <= init_have;
            xo_n <= 1'b1;
        end else begin
            xo_n <= ~(chain & pass);
            if (chain && pass)
                have <= 1'b0;
            else if (chain && !xi_n)
                have <= 1'b1;
        end
    end

    // R11: the hand-over pulse lasts exactly one clock
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !xo_n |=> xo_n);

    // R11: a link that hands its token on no longer holds it
    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && pass) |=> !have);

endmodule

// File: rtl/exp_fifo.sv
module exp_fifo
    import exp_fifo_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [WIDTH-1:0] din,
    input  logic             fl_rt_n,
    input  logic             xi_wr_n,
    input  logic             xi_rd_n,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             full,
    output logic             empty,
    output logic             xo_wr_n,
    output logic             xo_rd_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam int EV_RD = 0;
    localparam int EV_WR = 1;
    localparam int EV_RT = 2;

    strobe_ev_t [2:0] ev;
    fifo_mode_e       mode;
    logic             chain;
    logic             strap_single;
    logic             init_have;
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             lapped;
    logic             wr_arm, rd_arm;
    logic             wr_have, rd_have;
    logic             wr_start, wr_commit, rd_start, rd_commit, rt_go;
    logic             oe_q;
    logic [WIDTH-1:0] rdata;

    // Mode straps: both token inputs low during reset selects standalone use
    assign strap_single = ~xi_wr_n & ~xi_rd_n;
    assign init_have    = strap_single | ~fl_rt_n;

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= strap_single ? MODE_SINGLE : MODE_CHAIN;
    end
    assign chain = (mode == MODE_CHAIN);

    exp_fifo_edge #(.N(3)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n ({fl_rt_n, wr_n, rd_n}),
        .ev    (ev)
    );

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    assign wr_start  = ev[EV_WR].fall & ~full & wr_have;
    assign wr_commit = ev[EV_WR].rise & wr_arm;
    assign rd_start  = ev[EV_RD].fall & ~empty & rd_have;
    assign rd_commit = ev[EV_RD].rise & rd_arm;
    assign rt_go     = ev[EV_RT].rise & ~chain & rd_n & wr_n & ~rd_arm & ~wr_arm;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            rptr   <= '0;
            count  <= '0;
            lapped <= 1'b0;
            wr_arm <= 1'b0;
            rd_arm <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            if (wr_start)
                wr_arm <= 1'b1;
            else if (ev[EV_WR].rise)
                wr_arm <= 1'b0;

            if (rd_start)
                rd_arm <= 1'b1;
            else if (ev[EV_RD].rise)
                rd_arm <= 1'b0;

            if (wr_commit) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
                if (wptr == LAST)
                    lapped <= 1'b1;
            end

            if (rt_go)
                rptr <= '0;
            else if (rd_commit)
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;

            if (rt_go)
                count <= CW'(rewind_level(int'(wptr), lapped, DEPTH));
            else if (wr_commit && !rd_commit)
                count <= count + 1'b1;
            else if (rd_commit && !wr_commit)
                count <= count - 1'b1;

            oe_q <= ~rd_n & rd_have;
        end
    end

    exp_fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr_commit),
        .waddr (wptr),
        .wdata (din),
        .re    (rd_start),
        .raddr (rptr),
        .rdata (rdata)
    );

    exp_fifo_token u_wr_tok (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_have (init_have),
        .chain     (chain),
        .xi_n      (xi_wr_n),
        .pass      (wr_commit && (wptr == LAST)),
        .have      (wr_have),
        .xo_n      (xo_wr_n)
    );

    exp_fifo_token u_rd_tok (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_have (init_have),
        .chain     (chain),
        .xi_n      (xi_rd_n),
        .pass      (rd_commit && (rptr == LAST)),
        .have      (rd_have),
        .xo_n      (xo_rd_n)
    );

    assign dout_oe = oe_q;
    assign dout    = oe_q ? rdata : '0;

    // R4: occupancy never passes the store size
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R4: full only falls through a completed read or a rewind
    a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_commit && !rt_go) |=> full);

    // R5: empty only falls through a completed write or a rewind
    a_r5_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_commit && !rt_go) |=> empty);

    // R7: an inactive read strobe switches the output off on the next clock
    a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> !dout_oe);

    // R8: rewind moves only the read position
    a_r8_rewind_keeps_wptr: assert property (@(posedge clk) disable iff (!rst_n)
        rt_go |=> (rptr == '0 && wptr == $past(wptr)));

    // R10: no cycle completes at a link that lacks the matching token
    a_r10_commit_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit |-> wr_have) and (rd_commit |-> rd_have));

    // R12: in a chain the read position only moves on completed reads
    a_r12_chain_rptr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && !rd_commit) |=> rptr == $past(rptr));

endmodule

// File: tb/exp_fifo_bench.sv
`timescale 1ns/1ps
module exp_fifo_bench;

    localparam int W  = 9;
    localparam int SD = 8;
    localparam int CD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // standalone device
    logic         s_rd_n = 1'b1, s_wr_n = 1'b1, s_rt_n = 1'b1;
    logic [W-1:0] s_din = '0;
    logic [W-1:0] s_dout;
    logic         s_oe, s_full, s_empty, s_xow, s_xor;

    exp_fifo #(.WIDTH(W), .DEPTH(SD)) u_exp_fifo (
        .clk(clk), .rst_n(rst_n), .rd_n(s_rd_n), .wr_n(s_wr_n), .din(s_din),
        .fl_rt_n(s_rt_n), .xi_wr_n(1'b0), .xi_rd_n(1'b0),
        .dout(s_dout), .dout_oe(s_oe), .full(s_full), .empty(s_empty),
        .xo_wr_n(s_xow), .xo_rd_n(s_xor)
    );

    // two-link ring
    logic         c_rd_n = 1'b1, c_wr_n = 1'b1, c_fl1 = 1'b1;
    logic [W-1:0] c_din = '0;
    logic [W-1:0] c_dout0, c_dout1;
    logic         c_oe0, c_oe1, c_full0, c_full1, c_empty0, c_empty1;
    logic         xw0, xr0, xw1, xr1;

    exp_fifo #(.WIDTH(W), .DEPTH(CD)) u_link0 (
        .clk(clk), .rst_n(rst_n), .rd_n(c_rd_n), .wr_n(c_wr_n), .din(c_din),
        .fl_rt_n(1'b0), .xi_wr_n(xw1), .xi_rd_n(xr1),
        .dout(c_dout0), .dout_oe(c_oe0), .full(c_full0), .empty(c_empty0),
        .xo_wr_n(xw0), .xo_rd_n(xr0)
    );

    exp_fifo #(.WIDTH(W), .DEPTH(CD)) u_link1 (
        .clk(clk), .rst_n(rst_n), .rd_n(c_rd_n), .wr_n(c_wr_n), .din(c_din),
        .fl_rt_n(c_fl1), .xi_wr_n(xw0), .xi_rd_n(xr0),
        .dout(c_dout1), .dout_oe(c_oe1), .full(c_full1), .empty(c_empty1),
        .xo_wr_n(xw1), .xo_rd_n(xr1)
    );

    int pw0 = 0, pr0 = 0, pw1 = 0, pr1 = 0, s_pulses = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!xw0) pw0++;
            if (!xr0) pr0++;
            if (!xw1) pw1++;
            if (!xr1) pr1++;
            if (!s_xow || !s_xor) s_pulses++;
        end
    end

    function automatic logic [W-1:0] pat(input int i);
        return W'((i * 37 + 11) % 512);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2: a decoy word is on din during the cycle, the real one at the rise
    task automatic s_write(input logic [W-1:0] d);
        @(negedge clk);
        s_wr_n = 1'b0;
        s_din  = ~d;
        @(negedge clk);
        s_din  = d;
        s_wr_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic s_read(output logic [W-1:0] d);
        @(negedge clk);
        s_rd_n = 1'b0;
        @(negedge clk);
        d = s_dout;
        chk("R7 oe during read", int'(s_oe), 1);
        s_rd_n = 1'b1;
        @(negedge clk);
        chk("R7 oe after read", int'(s_oe), 0);
        chk("R7 dout zero when off", int'(s_dout), 0);
        @(negedge clk);
    endtask

    task automatic s_rewind();
        @(negedge clk);
        s_rt_n = 1'b0;
        @(negedge clk);
        s_rt_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic c_write(input logic [W-1:0] d);
        @(negedge clk);
        c_wr_n = 1'b0;
        c_din  = ~d;
        @(negedge clk);
        c_din  = d;
        c_wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic c_read(output logic [W-1:0] d, output logic o0, output logic o1);
        @(negedge clk);
        c_rd_n = 1'b0;
        @(negedge clk);
        d  = c_dout0 | c_dout1;
        o0 = c_oe0;
        o1 = c_oe1;
        c_rd_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] d;
        logic o0, o1;
        int seq_w, seq_r;

        // R1: reset state
        do_reset();
        chk("R1 empty", int'(s_empty), 1);
        chk("R1 full", int'(s_full), 0);
        chk("R1 oe", int'(s_oe), 0);
        chk("R1 dout", int'(s_dout), 0);
        chk("R1 xo_wr", int'(s_xow), 1);
        chk("R1 xo_rd", int'(s_xor), 1);

        // R4 R5: fill to the brim
        for (int i = 0; i < SD; i++) begin
            s_write(pat(i));
            chk("R5 empty after write", int'(s_empty), 0);
            chk("R4 full level", int'(s_full), (i == SD - 1) ? 1 : 0);
        end
        s_write(pat(100));
        chk("R4 full after dropped write", int'(s_full), 1);

        // R3 R6: drain, dropped word must not appear
        for (int i = 0; i < SD; i++) begin
            s_read(d);
            chk("R3 R2 read data", int'(d), int'(pat(i)));
            chk("R4 full cleared by read", int'(s_full), 0);
            chk("R5 empty level", int'(s_empty), (i == SD - 1) ? 1 : 0);
        end

        // R5: read while empty is ignored
        s_read(d);
        chk("R5 empty after ignored read", int'(s_empty), 1);
        s_write(pat(200));
        s_read(d);
        chk("R5 position kept by ignored read", int'(d), int'(pat(200)));

        // R6: bursts of every length across the wrap
        seq_w = 300;
        seq_r = 300;
        for (int lvl = 1; lvl <= SD; lvl++) begin
            for (int k = 0; k < lvl; k++) begin
                s_write(pat(seq_w));
                seq_w++;
            end
            chk("R4 full at burst top", int'(s_full), (lvl == SD) ? 1 : 0);
            for (int k = 0; k < lvl; k++) begin
                s_read(d);
                chk("R6 order across wrap", int'(d), int'(pat(seq_r)));
                seq_r++;
            end
            chk("R5 empty after burst", int'(s_empty), 1);
        end
        chk("R11 standalone outputs quiet", s_pulses, 0);

        // R8: rewind after partial read
        do_reset();
        s_rewind();
        chk("R8 rewind on fresh store keeps empty", int'(s_empty), 1);
        for (int i = 0; i < 5; i++) s_write(pat(600 + i));
        for (int i = 0; i < 3; i++) s_read(d);
        s_rewind();
        chk("R8 empty after rewind", int'(s_empty), 0);
        for (int i = 0; i < 5; i++) begin
            s_read(d);
            chk("R8 reread data", int'(d), int'(pat(600 + i)));
        end
        chk("R8 empty after reread", int'(s_empty), 1);

        // R8: rewind after exactly one lap
        do_reset();
        for (int i = 0; i < SD; i++) s_write(pat(700 + i));
        for (int i = 0; i < SD; i++) s_read(d);
        s_rewind();
        chk("R8 full after lap rewind", int'(s_full), 1);
        for (int i = 0; i < SD; i++) begin
            s_read(d);
            chk("R8 lap reread data", int'(d), int'(pat(700 + i)));
        end

        // R9: rewind during an open write, then during an open read
        do_reset();
        for (int i = 0; i < 3; i++) s_write(pat(800 + i));
        s_read(d);
        @(negedge clk);
        s_wr_n = 1'b0;
        s_din  = pat(803);
        @(negedge clk);
        s_rt_n = 1'b0;
        @(negedge clk);
        s_rt_n = 1'b1;
        @(negedge clk);
        s_wr_n = 1'b1;
        repeat (2) @(negedge clk);
        s_read(d);
        chk("R9 rewind ignored under write strobe", int'(d), int'(pat(801)));
        @(negedge clk);
        s_rd_n = 1'b0;
        @(negedge clk);
        d = s_dout;
        s_rt_n = 1'b0;
        @(negedge clk);
        s_rt_n = 1'b1;
        @(negedge clk);
        s_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 read under rewind pulse", int'(d), int'(pat(802)));
        s_read(d);
        chk("R9 rewind ignored under read strobe", int'(d), int'(pat(803)));

        // R10 R11: two-link ring
        do_reset();
        pw0 = 0; pr0 = 0; pw1 = 0; pr1 = 0;
        c_write(pat(900));
        chk("R10 first link takes first word", int'(c_empty0), 0);
        chk("R10 second link idle", int'(c_empty1), 1);
        for (int i = 1; i < CD; i++) c_write(pat(900 + i));
        chk("R11 first link full", int'(c_full0), 1);
        chk("R11 write token pulse count", pw0, 1);
        c_write(pat(900 + CD));
        c_write(pat(901 + CD));
        chk("R11 second link took token", int'(c_empty1), 0);
        chk("R11 second link no pulse yet", pw1, 0);
        for (int i = 0; i < CD + 1; i++) begin
            c_read(d, o0, o1);
            chk("R11 ring order", int'(d), int'(pat(900 + i)));
            chk("R10 holder drives", int'(o0), (i < CD) ? 1 : 0);
            chk("R10 other link off", int'(o1), (i < CD) ? 0 : 1);
        end
        chk("R11 read token pulse count", pr0, 1);

        // R12: pulse on the second link's first-load pin does nothing
        @(negedge clk);
        c_fl1 = 1'b0;
        @(negedge clk);
        c_fl1 = 1'b1;
        repeat (2) @(negedge clk);
        c_read(d, o0, o1);
        chk("R12 no rewind in ring", int'(d), int'(pat(901 + CD)));
        chk("R5 ring drained", int'(c_empty1), 1);

        finish_run();
    end

endmodule